// File: doc/BRIEF.md
# PWM Compare Channel with Trigger Fast Path

This block is one channel of a timer. It compares an externally supplied free-running counter value with a compare value and drives a single compare output. Two PWM modes are provided, one the inverse of the other. Force and hold modes are also available.

An external trigger input is brought into the clock domain and reduced to a one-cycle event pulse. The pulse is exported so that the counter logic, which sits outside this block, can restart its count. That gives a 5-cycle path from a trigger edge to a changed output. When the fast-enable bit is set and the channel is in a PWM mode, the same event pulse skips the comparator and writes the output register directly. That shortens the path to 3 cycles.

A 2-bit role field decides whether the channel drives its output or is used as an input. Software may change this field only while the channel is disabled. The output pin is driven only while the channel is enabled in the output role.

Top module: `pwm_fastpath_channel`

## Requirements
- R1: After reset, `cmp_out_o` is 0, `trig_evt_o` is 0 and `role_o` is 00.
- R2: In PWM mode 1 (`mode_i` = 3'b110), the output is 1 when `cnt_i < cmp_i` and 0 otherwise. A change on `cnt_i` or `cmp_i` appears on the output after the second rising clock edge.
- R3: In PWM mode 2 (`mode_i` = 3'b111), the output is the inverse of the PWM mode 1 result, with the same 2-edge latency.
- R4: Mode 3'b010 forces the output to 1 and mode 3'b001 forces it to 0. Mode 3'b000 holds the current output, and so do the unused codes 3'b011, 3'b100 and 3'b101.
- R5: A rising edge on `trig_i` that is sampled at clock edge E0 makes `trig_evt_o` high from edge E2 to edge E3. There is exactly one pulse for each rising edge.
- R6: With `fast_en_i` = 0, the trigger has no direct effect on the output. If the counter restarts from `trig_evt_o`, the new compare result reaches the output at edge E5 and not before.
- R7: With `fast_en_i` = 1 in a PWM mode, the event pulse drives the output to the match level at edge E3, whatever the comparison result. The match level is 0 in PWM mode 1 and 1 in PWM mode 2. The output returns to the compare result at the next edge.
- R8: In modes other than the two PWM modes, `fast_en_i` has no effect on the output.
- R9: Role 00 is output and role 01 is input. `cmp_out_o` follows the output register only when `chan_en_i` = 1 and the role is 00; otherwise it is 0.
- R10: A write of the role field while `chan_en_i` = 1 is ignored.
- R11: A write of a reserved role code (10 or 11) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current counter value |
| cmp_i | input | CNT_W | Compare value |
| mode_i | input | 3 | Output mode code |
| fast_en_i | input | 1 | Trigger fast-path enable |
| chan_en_i | input | 1 | Channel enable |
| role_wr_i | input | 1 | Write strobe for the role field |
| role_wdata_i | input | 2 | Role value to write |
| trig_i | input | 1 | Asynchronous trigger input |
| trig_evt_o | output | 1 | One-cycle trigger event (counter restart request) |
| role_o | output | 2 | Current role field |
| cmp_out_o | output | 1 | Compare output |

## Verification
The assertions assume that `trig_i` stays high or low long enough to pass both synchronizer flops. They also assume that only reset initialises the role register. The stimulus keeps the trigger at each level for several cycles and lets the synchronizer settle between trigger tests. Mode, compare value and fast enable change only on falling edges, and they stay steady over the cycles in which an output is checked. The counter is modelled in the bench as a held value that is cleared by the event pulse, so the 5-cycle path can be counted exactly.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD     = 3'b000,
        MODE_FORCE_LO = 3'b001,
        MODE_FORCE_HI = 3'b010,
        MODE_PWM1     = 3'b110,
        MODE_PWM2     = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        ROLE_OUTPUT = 2'b00,
        ROLE_INPUT  = 2'b01
    } role_e;

    function automatic logic is_pwm(input logic [2:0] m);
        return (m == MODE_PWM1) || (m == MODE_PWM2);
    endfunction

    function automatic logic match_level(input logic [2:0] m);
        return (m == MODE_PWM2);
    endfunction

    function automatic logic role_legal(input logic [1:0] r);
        return (r == ROLE_OUTPUT) || (r == ROLE_INPUT);
    endfunction

endpackage

// File: rtl/pwmch_trig_sync.sv
module pwmch_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic evt_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   evt;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], trig_i};
        st_d.prev = st_q.sync[MSB];
        st_d.evt  = st_q.sync[MSB] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;

    // R5
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);

    // R5
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.evt) |-> st_q.prev);

endmodule

// File: rtl/pwmch_cmp_stage.sv
module pwmch_cmp_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             below_o
);
    typedef struct packed {
        logic below;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.below = (cnt_i < cmp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign below_o = st_q.below;

endmodule

// File: rtl/pwmch_role_ctl.sv
module pwmch_role_ctl
    import pwmch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output logic [1:0] role_o,
    output logic       drive_o
);
    typedef struct packed {
        logic [1:0] role;
    } role_st_t;

    role_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && !en_i && role_legal(wdata_i)) begin
            st_d.role = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign role_o  = st_q.role;
    assign drive_o = en_i && (st_q.role == ROLE_OUTPUT);

    // R10
    role_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable(st_q.role));

    // R11
    role_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.role[1]);

endmodule

// File: rtl/pwm_fastpath_channel.sv
module pwm_fastpath_channel
    import pwmch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [2:0]       mode_i,
    input  logic             fast_en_i,
    input  logic             chan_en_i,
    input  logic             role_wr_i,
    input  logic [1:0]       role_wdata_i,
    input  logic             trig_i,
    output logic             trig_evt_o,
    output logic [1:0]       role_o,
    output logic             cmp_out_o
);
    logic evt;
    logic below;
    logic drive;

    pwmch_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .evt_o  (evt)
    );

    pwmch_cmp_stage #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .cmp_i   (cmp_i),
        .below_o (below)
    );

    pwmch_role_ctl u_role (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (chan_en_i),
        .wr_i    (role_wr_i),
        .wdata_i (role_wdata_i),
        .role_o  (role_o),
        .drive_o (drive)
    );

    typedef struct packed {
        logic out;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fast_en_i && evt && is_pwm(mode_i)) begin
            st_d.out = match_level(mode_i);
        end else begin
            unique case (mode_i)
                MODE_PWM1:     st_d.out = below;
                MODE_PWM2:     st_d.out = ~below;
                MODE_FORCE_HI: st_d.out = 1'b1;
                MODE_FORCE_LO: st_d.out = 1'b0;
                default:       st_d.out = st_q.out;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_evt_o = evt;
    assign cmp_out_o  = st_q.out & drive;

    // R7
    fast_pwm1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && fast_en_i && mode_i == MODE_PWM1) |=> !st_q.out);

    // R7
    fast_pwm2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && fast_en_i && mode_i == MODE_PWM2) |=> st_q.out);

    // R8
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FORCE_HI) |=> st_q.out);

    // R9
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role_o != ROLE_OUTPUT) |-> !cmp_out_o);

endmodule

// File: tb/pwm_fastpath_channel_bench.sv
module pwm_fastpath_channel_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cnt_set = '0;
    logic [W-1:0] cmp_i = '0;
    logic [2:0] mode_i = 3'b000;
    logic fast_en_i = 1'b0;
    logic chan_en_i = 1'b0;
    logic role_wr_i = 1'b0;
    logic [1:0] role_wdata_i = 2'b00;
    logic trig_i = 1'b0;
    logic trig_evt_o;
    logic [1:0] role_o;
    logic cmp_out_o;
    logic restarted = 1'b0;
    logic clr_restart = 1'b0;
    logic [W-1:0] cnt_i;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Counter model: a held value that the event pulse clears.
    always @(posedge clk) begin
        if (clr_restart)     restarted <= 1'b0;
        else if (trig_evt_o) restarted <= 1'b1;
    end
    assign cnt_i = restarted ? '0 : cnt_set;

    pwm_fastpath_channel #(.CNT_W(W)) u_pwm_fastpath_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp_i),
        .mode_i(mode_i), .fast_en_i(fast_en_i), .chan_en_i(chan_en_i),
        .role_wr_i(role_wr_i), .role_wdata_i(role_wdata_i), .trig_i(trig_i),
        .trig_evt_o(trig_evt_o), .role_o(role_o), .cmp_out_o(cmp_out_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {mode, cnt, cmp, expected output}
    localparam logic [35:0] VEC [14] = '{
        {3'b110, 16'd3,     16'd10,    1'b1},
        {3'b110, 16'd10,    16'd10,    1'b0},
        {3'b110, 16'd11,    16'd10,    1'b0},
        {3'b110, 16'd0,     16'd0,     1'b0},
        {3'b110, 16'd0,     16'd1,     1'b1},
        {3'b110, 16'hFFFF,  16'hFFFF,  1'b0},
        {3'b111, 16'd3,     16'd10,    1'b0},
        {3'b111, 16'd10,    16'd10,    1'b1},
        {3'b111, 16'hFFFE,  16'hFFFF,  1'b0},
        {3'b010, 16'd20,    16'd10,    1'b1},
        {3'b011, 16'd20,    16'd10,    1'b1},
        {3'b001, 16'd3,     16'd10,    1'b0},
        {3'b000, 16'd3,     16'd10,    1'b0},
        {3'b100, 16'd3,     16'd10,    1'b0}
    };

    // Raises the trigger at a falling edge; the next rising edge is E0.
    task automatic trig_pulse_start();
        @(negedge clk);
        trig_i = 1'b1;
    endtask

    task automatic trig_settle();
        trig_i = 1'b0;
        ticks(5);
        clr_restart = 1'b1;
        ticks(1);
        clr_restart = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ticks(2);
        chk("R1 out", {3'b0, cmp_out_o}, 4'h0);
        chk("R1 evt", {3'b0, trig_evt_o}, 4'h0);
        chk("R1 role", {2'b0, role_o}, 4'h0);
        rst_n = 1'b1;
        chan_en_i = 1'b1;
        ticks(1);

        // R2 R3 R4: table of compare and mode vectors
        for (int k = 0; k < 14; k++) begin
            mode_i  = VEC[k][35:33];
            cnt_set = VEC[k][32:17];
            cmp_i   = VEC[k][16:1];
            ticks(2);
            chk((mode_i == 3'b110) ? "R2 pwm1" : (mode_i == 3'b111) ? "R3 pwm2" : "R4 force/hold",
                {3'b0, cmp_out_o}, {3'b0, VEC[k][0]});
        end

        // R2 latency: only one edge after a change is not enough
        mode_i = 3'b110; cmp_i = 16'd10; cnt_set = 16'd3;
        ticks(3);
        cnt_set = 16'd12;
        ticks(1);
        chk("R2 latency one edge", {3'b0, cmp_out_o}, 4'h1);
        ticks(1);
        chk("R2 latency two edges", {3'b0, cmp_out_o}, 4'h0);

        // R5 R6: normal path, counter restart gives 5-cycle response
        fast_en_i = 1'b0; mode_i = 3'b110; cmp_i = 16'd10; cnt_set = 16'd20;
        ticks(3);
        chk("R6 pre", {3'b0, cmp_out_o}, 4'h0);
        trig_pulse_start();
        ticks(2);
        chk("R5 evt before E2", {3'b0, trig_evt_o}, 4'h0);
        ticks(1);
        chk("R5 evt after E2", {3'b0, trig_evt_o}, 4'h1);
        ticks(1);
        chk("R5 evt single", {3'b0, trig_evt_o}, 4'h0);
        ticks(1);
        chk("R6 not before E5", {3'b0, cmp_out_o}, 4'h0);
        ticks(1);
        chk("R6 at E5", {3'b0, cmp_out_o}, 4'h1);
        ticks(3);
        chk("R5 no repeat while high", {3'b0, trig_evt_o}, 4'h0);
        trig_settle();

        // R7: fast path in PWM mode 1
        fast_en_i = 1'b1; mode_i = 3'b110; cmp_i = 16'd10; cnt_set = 16'd3;
        ticks(3);
        trig_pulse_start();
        ticks(3);
        chk("R7 pwm1 before E3", {3'b0, cmp_out_o}, 4'h1);
        ticks(1);
        chk("R7 pwm1 at E3", {3'b0, cmp_out_o}, 4'h0);
        ticks(1);
        chk("R7 pwm1 after", {3'b0, cmp_out_o}, 4'h1);
        trig_settle();

        // R7: fast path in PWM mode 2
        mode_i = 3'b111;
        ticks(3);
        chk("R7 pwm2 pre", {3'b0, cmp_out_o}, 4'h0);
        trig_pulse_start();
        ticks(4);
        chk("R7 pwm2 at E3", {3'b0, cmp_out_o}, 4'h1);
        ticks(1);
        chk("R7 pwm2 after", {3'b0, cmp_out_o}, 4'h0);
        trig_settle();

        // R6: fast off, no direct effect at E3
        fast_en_i = 1'b0; mode_i = 3'b110;
        ticks(3);
        trig_pulse_start();
        ticks(4);
        chk("R6 no effect at E3", {3'b0, cmp_out_o}, 4'h1);
        trig_settle();

        // R8: fast enable ignored in force-high and hold
        fast_en_i = 1'b1; mode_i = 3'b010;
        ticks(3);
        trig_pulse_start();
        for (int j = 0; j < 6; j++) begin
            ticks(1);
            chk("R8 force hi", {3'b0, cmp_out_o}, 4'h1);
        end
        trig_settle();
        mode_i = 3'b000;
        trig_pulse_start();
        ticks(4);
        chk("R8 hold", {3'b0, cmp_out_o}, 4'h1);
        trig_settle();
        fast_en_i = 1'b0;

        // R10: write while enabled is ignored
        mode_i = 3'b010;
        role_wr_i = 1'b1; role_wdata_i = 2'b01;
        ticks(1);
        role_wr_i = 1'b0;
        ticks(1);
        chk("R10 role locked", {2'b0, role_o}, 4'h0);
        chk("R10 still driving", {3'b0, cmp_out_o}, 4'h1);

        // R9: disable masks output; role switch to input
        chan_en_i = 1'b0;
        ticks(1);
        chk("R9 disabled mask", {3'b0, cmp_out_o}, 4'h0);
        role_wr_i = 1'b1; role_wdata_i = 2'b01;
        ticks(1);
        role_wr_i = 1'b0;
        chk("R9 role input", {2'b0, role_o}, 4'h1);
        chan_en_i = 1'b1;
        ticks(1);
        chk("R9 input role mask", {3'b0, cmp_out_o}, 4'h0);

        // R11: reserved codes ignored
        chan_en_i = 1'b0;
        role_wr_i = 1'b1; role_wdata_i = 2'b10;
        ticks(1);
        role_wdata_i = 2'b11;
        ticks(1);
        role_wr_i = 1'b0;
        chk("R11 reserved ignored", {2'b0, role_o}, 4'h1);

        // R9: back to output role drives again
        role_wr_i = 1'b1; role_wdata_i = 2'b00;
        ticks(1);
        role_wr_i = 1'b0;
        chan_en_i = 1'b1;
        ticks(1);
        chk("R9 output role", {2'b0, role_o}, 4'h0);
        chk("R9 drive restored", {3'b0, cmp_out_o}, 4'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule